// File: doc/BRIEF.md
# DMA Word Port with Request/Acknowledge Handshake

This block is the side of a peripheral controller that faces an external DMA engine. It moves 16-bit words between that engine and a 16-entry internal FIFO. An active-high request line asks the engine for service. An active-low acknowledge serves as the chip select for the block's read drivers. Separate active-low read and write strobes move one word each, and the word is taken at the rising (trailing) edge of the strobe. The far side of the FIFO is a plain push/pop port for the controller core.

A start pulse loads the transfer length and a direction. In read direction the FIFO is drained onto the bus. In write direction the bus fills the FIFO. The block pulls the request low at the falling (leading) edge of a strobe when the beat in progress will be the last one for now. A beat is the last for now if it fills the last free FIFO entry, takes the last stored word, or completes the programmed count. Strobes that arrive while the request is low do nothing. Write data carries one odd-parity bit per byte, which the block checks but never generates. Read data leaves with parity the block computes itself. The strobes are brought into the system clock through two-flop synchronizers, so the system clock must resolve a 15 ns strobe pulse.

Top module: `dma_word_port`

## Requirements
- R1: After reset, dreq, bus_oe, done and par_err are 0 and fifo_empty is 1.
- R2: In write direction (dir_rd=0), each completed write strobe (wr_n falling then rising while the request was high at the falling edge) stores bus_din into the FIFO. The core side reads the words back in arrival order through core_pop/core_rdata.
- R3: In read direction (dir_rd=1), the core side fills the FIFO with core_push/core_wdata. bus_dout shows the oldest word. Each completed read strobe removes that word, so the words leave in push order.
- R4: start loads xfer_len. After exactly that many completed strobes, done pulses high for one cycle and dreq stays low until the next start. A start with xfer_len of 0 raises neither dreq nor done.
- R5: In write direction, dreq falls at the leading edge of the strobe whose word will occupy the last free entry. The FIFO therefore never takes more than 16 words, and fifo_full is then 1.
- R6: In read direction, dreq falls at the leading edge of the strobe that takes the last stored word. No strobe ever reads an empty FIFO.
- R7: dreq rises only while a transfer is active and not mid-strobe. It needs at least 2 words available (free entries for writes, stored words for reads), or exactly 1 available while 1 word of count remains.
- R8: A strobe whose falling edge arrives while dreq is low moves no word and does not change the remaining count.
- R9: bus_oe is 1 only while a read-direction transfer is active and dack_n is low. It is 0 whenever dack_n is high.
- R10: Write parity is odd per byte: bus_pin[i] covers bus_din[8i+7:8i], and the XOR of the byte and its bit must be 1. Any completed write beat with a mismatch on either byte sets par_err, which stays set until the next start.
- R11: On reads, bus_pout[i] is the odd-parity bit of bus_dout[8i+7:8i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse: load length and direction, clear parity error |
| dir_rd | input | 1 | 1 = FIFO to bus, 0 = bus to FIFO (sampled at start) |
| xfer_len | input | 16 | Number of words in the transfer |
| dreq | output | 1 | DMA request, active high |
| dack_n | input | 1 | DMA acknowledge / read driver select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| bus_din | input | 16 | Write data from the DMA bus |
| bus_pin | input | 2 | Write parity, one bit per byte |
| bus_dout | output | 16 | Read data to the DMA bus |
| bus_pout | output | 2 | Read parity, one bit per byte |
| bus_oe | output | 1 | Enable for the DMA bus drivers |
| core_push | input | 1 | Core-side push (read direction) |
| core_wdata | input | 16 | Core-side push data |
| core_pop | input | 1 | Core-side pop (write direction) |
| core_rdata | output | 16 | Oldest FIFO word |
| fifo_full | output | 1 | FIFO holds 16 words |
| fifo_empty | output | 1 | FIFO holds no words |
| done | output | 1 | One-cycle pulse when the count reaches zero |
| par_err | output | 1 | Sticky write parity error |

## Verification
The hardest case to reach is a transfer that stalls on the FIFO limit partway through its count and must then resume. The request drops one beat early, the strobe in flight must still complete, and the request must come back only when the FIFO has room again. The bench reaches this in write direction by holding the core-side drain off through a 20-word transfer. That forces a stall after 16 beats. A stray strobe is sent while the request is low, then the drain is released and the remaining 4 words are collected. In read direction it supplies only half of a 6-word transfer, strobes once while stalled, then tops up the FIFO. A final beat count of exactly 3 shows the stray strobe was not counted.

// File: rtl/dma_word_port.sv
module dma_word_port #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  parameter int CW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir_rd,
  input  logic [CW-1:0]    xfer_len,
  output logic             dreq,
  input  logic             dack_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic [DW-1:0]    bus_din,
  input  logic [DW/8-1:0]  bus_pin,
  output logic [DW-1:0]    bus_dout,
  output logic [DW/8-1:0]  bus_pout,
  output logic             bus_oe,
  input  logic             core_push,
  input  logic [DW-1:0]    core_wdata,
  input  logic             core_pop,
  output logic [DW-1:0]    core_rdata,
  output logic             fifo_full,
  output logic             fifo_empty,
  output logic             done,
  output logic             par_err
);
  localparam int NB = DW / 8;
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic [2:0]    s_rd, s_wr;
  logic          dir_q, busy, armed;
  logic [CW-1:0] cnt;
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] level, avail;
  logic [NB-1:0] perr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s_rd <= '1;
      s_wr <= '1;
    end else begin
      s_rd <= {s_rd[1:0], rd_n};
      s_wr <= {s_wr[1:0], wr_n};
    end

  wire rd_fall  = s_rd[2] & ~s_rd[1];
  wire rd_rise  = ~s_rd[2] & s_rd[1];
  wire wr_fall  = s_wr[2] & ~s_wr[1];
  wire wr_rise  = ~s_wr[2] & s_wr[1];
  wire stb_fall = dir_q ? rd_fall : wr_fall;
  wire stb_rise = dir_q ? rd_rise : wr_rise;

  wire accept   = busy & dreq & ~armed & stb_fall;
  wire beat     = armed & stb_rise;
  wire last_cnt = (cnt == CW'(1));

  assign fifo_full  = (level == LW'(DEPTH));
  assign fifo_empty = (level == '0);
  assign avail      = dir_q ? level : LW'(DEPTH) - level;

  wire drop_now = last_cnt | (avail <= LW'(1));
  wire raise_ok = busy & ~dreq & ~armed & (cnt != '0) &
                  ((avail >= LW'(2)) | ((avail == LW'(1)) & last_cnt));

  wire wr_en = (dir_q ? core_push : (beat & ~dir_q)) & ~fifo_full;
  wire rd_en = (dir_q ? (beat & dir_q) : core_pop) & ~fifo_empty;
  wire [DW-1:0] wdata = dir_q ? core_wdata : bus_din;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dir_q <= 1'b0;
      busy  <= 1'b0;
      cnt   <= '0;
      armed <= 1'b0;
      dreq  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        dir_q <= dir_rd;
        busy  <= (xfer_len != '0);
        cnt   <= xfer_len;
        armed <= 1'b0;
        dreq  <= 1'b0;
      end else begin
        if (accept) armed <= 1'b1;
        else if (stb_rise) armed <= 1'b0;
        if (beat) begin
          cnt <= cnt - CW'(1);
          if (last_cnt) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
        if (!busy) dreq <= 1'b0;
        else if (accept && drop_now) dreq <= 1'b0;
        else if (raise_ok) dreq <= 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (wr_en) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      if (rd_en) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      case ({wr_en, rd_en})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end

  always_ff @(posedge clk)
    if (wr_en) mem[wptr] <= wdata;

  assign core_rdata = mem[rptr];
  assign bus_dout   = mem[rptr];
  assign bus_oe     = busy & dir_q & ~dack_n;

  for (genvar i = 0; i < NB; i++) begin : g_par
    assign bus_pout[i] = ~^bus_dout[i*8 +: 8];
    assign perr[i]     = ~^{bus_din[i*8 +: 8], bus_pin[i]};
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) par_err <= 1'b0;
    else if (start) par_err <= 1'b0;
    else if (beat && !dir_q && |perr) par_err <= 1'b1;

  a_r4_last_beat_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && last_cnt && !start) |=> (!dreq && !busy && done));
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r4_dreq_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
    dreq |-> (busy && cnt != '0));
  a_r5_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
  a_r8_idle_count_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!dreq && !armed && !start) |=> $stable(cnt));
  a_r7_raise_has_room: assert property (@(posedge clk) disable iff (!rst_n)
    (!dreq && !start) ##1 dreq |-> (avail != '0));
  a_r6_no_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && dir_q) |-> !fifo_empty);
endmodule

// File: tb/dma_word_port_bench.sv
module dma_word_port_bench;
  logic clk = 0, rst_n = 0;
  logic start = 0, dir_rd = 0;
  logic [15:0] xfer_len = '0;
  logic dack_n = 1, rd_n = 1, wr_n = 1;
  logic [15:0] bus_din = '0;
  logic [1:0]  bus_pin = '0;
  logic core_push = 0, core_pop = 0;
  logic [15:0] core_wdata = '0;
  wire  [15:0] bus_dout, core_rdata;
  wire  [1:0]  bus_pout;
  wire dreq, bus_oe, fifo_full, fifo_empty, done, par_err;

  dma_word_port u_dma_word_port (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_rd(dir_rd), .xfer_len(xfer_len),
    .dreq(dreq), .dack_n(dack_n), .rd_n(rd_n), .wr_n(wr_n),
    .bus_din(bus_din), .bus_pin(bus_pin), .bus_dout(bus_dout), .bus_pout(bus_pout),
    .bus_oe(bus_oe), .core_push(core_push), .core_wdata(core_wdata), .core_pop(core_pop),
    .core_rdata(core_rdata), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .done(done), .par_err(par_err));

  always #2 clk = ~clk;

  int n_tests = 0, n_fail = 0, done_cnt = 0;
  bit drain_on = 0, finished = 0;
  logic [15:0] wq[$];
  logic [15:0] rq[$];
  logic [15:0] seed = 16'h1357;

  function automatic logic [1:0] opar(input logic [15:0] w);
    return {~^w[15:8], ~^w[7:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) if (done) done_cnt++;

  // monitor: drains the FIFO on the core side in write direction
  always @(negedge clk) begin
    core_pop <= 0;
    if (drain_on && !fifo_empty) begin
      if (wq.size() == 0) chk(0, "R2 unexpected word", core_rdata, 0);
      else begin
        logic [15:0] e;
        e = wq.pop_front();
        chk(core_rdata == e, "R2 write data order", core_rdata, e);
      end
      core_pop <= 1;
    end
  end

  task automatic begin_xfer(input bit rd, input int len);
    @(negedge clk);
    dir_rd = rd; xfer_len = 16'(len); start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_dreq(output bit got);
    got = 0;
    for (int i = 0; i < 400; i++) begin
      if (dreq) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic dma_write(input int bad_at, output int n);
    bit got;
    n = 0;
    wait_dreq(got);
    if (!got) return;
    dack_n = 0;
    while (dreq) begin
      seed = seed * 16'd25173 + 16'd13849;
      bus_din = seed;
      bus_pin = opar(seed);
      if (n == bad_at) bus_pin[1] = ~bus_pin[1];
      wq.push_back(seed);
      wr_n = 0;
      repeat (10) @(negedge clk);
      wr_n = 1;
      repeat (10) @(negedge clk);
      n++;
    end
    dack_n = 1;
  endtask

  task automatic dma_read(output int n);
    bit got;
    n = 0;
    wait_dreq(got);
    if (!got) return;
    dack_n = 0;
    @(negedge clk);
    while (dreq) begin
      logic [15:0] e;
      rd_n = 0;
      repeat (5) @(negedge clk);
      chk(bus_oe == 1, "R9 drivers on with dack low", bus_oe, 1);
      e = (rq.size() != 0) ? rq.pop_front() : 16'hxxxx;
      chk(bus_dout === e, "R3 read data order", bus_dout, e);
      chk(bus_pout == opar(bus_dout), "R11 read parity", bus_pout, opar(bus_dout));
      repeat (5) @(negedge clk);
      rd_n = 1;
      repeat (10) @(negedge clk);
      n++;
    end
    dack_n = 1;
  endtask

  task automatic core_fill(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      seed = seed * 16'd25173 + 16'd13849;
      core_wdata = seed; core_push = 1;
      rq.push_back(seed);
    end
    @(negedge clk);
    core_push = 0;
  endtask

  task automatic stray_strobe(input bit rd);
    if (rd) rd_n = 0; else wr_n = 0;
    bus_din = 16'hdead; bus_pin = opar(16'hdead);
    repeat (10) @(negedge clk);
    rd_n = 1; wr_n = 1;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int n, d0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(dreq == 0 && bus_oe == 0, "R1 reset outputs", {dreq, bus_oe}, 0);
    chk(done == 0 && par_err == 0, "R1 reset flags", {done, par_err}, 0);
    chk(fifo_empty == 1, "R1 reset empty", fifo_empty, 1);

    // plain write of 5 words
    drain_on = 1; d0 = done_cnt;
    begin_xfer(0, 5);
    dma_write(-1, n);
    chk(n == 5, "R4 write beat count", n, 5);
    repeat (20) @(negedge clk);
    chk(wq.size() == 0, "R2 all words delivered", wq.size(), 0);
    chk(done_cnt == d0 + 1, "R4 single done pulse", done_cnt - d0, 1);
    chk(dreq == 0, "R4 dreq low after count", dreq, 0);

    // strobe while idle is ignored
    drain_on = 0;
    stray_strobe(0);
    chk(fifo_empty == 1, "R8 idle write strobe ignored", fifo_empty, 1);

    // write overrun stall
    d0 = done_cnt;
    begin_xfer(0, 20);
    dma_write(-1, n);
    chk(n == 16, "R5 stall after fill", n, 16);
    chk(fifo_full == 1 && dreq == 0, "R5 full and dreq low", {fifo_full, dreq}, 2'b10);
    stray_strobe(0);
    drain_on = 1;
    dma_write(-1, n);
    chk(n == 4, "R8 stray strobe not counted", n, 4);
    repeat (20) @(negedge clk);
    chk(wq.size() == 0, "R2 words after stall", wq.size(), 0);
    chk(done_cnt == d0 + 1, "R4 done after resume", done_cnt - d0, 1);
    drain_on = 0;

    // read underrun stall
    d0 = done_cnt;
    begin_xfer(1, 6);
    chk(bus_oe == 0, "R9 drivers off with dack high", bus_oe, 0);
    core_fill(3);
    dma_read(n);
    chk(n == 3, "R6 stall at empty", n, 3);
    chk(fifo_empty == 1 && dreq == 0, "R6 empty and dreq low", {fifo_empty, dreq}, 2'b10);
    stray_strobe(1);
    core_fill(3);
    dma_read(n);
    chk(n == 3, "R8 read stray not counted", n, 3);
    chk(done_cnt == d0 + 1, "R4 read done", done_cnt - d0, 1);

    // single word with single count (R7 special case)
    begin_xfer(1, 1);
    core_fill(1);
    dma_read(n);
    chk(n == 1, "R7 one available one remaining", n, 1);
    chk(dreq == 0, "R7 dreq low after last", dreq, 0);

    // read with one word but more remaining must not raise
    begin_xfer(1, 4);
    core_fill(1);
    repeat (20) @(negedge clk);
    chk(dreq == 0, "R7 no raise with one word", dreq, 0);
    core_fill(3);
    dma_read(n);
    chk(n == 4, "R7 raise after top-up", n, 4);

    // write parity error, sticky then cleared
    drain_on = 1;
    begin_xfer(0, 2);
    dma_write(1, n);
    repeat (10) @(negedge clk);
    chk(par_err == 1, "R10 parity error flagged", par_err, 1);
    begin_xfer(0, 1);
    chk(par_err == 0, "R10 cleared by start", par_err, 0);
    dma_write(-1, n);
    repeat (10) @(negedge clk);
    chk(par_err == 0, "R10 good parity no error", par_err, 0);

    // zero length
    d0 = done_cnt;
    begin_xfer(0, 0);
    repeat (30) @(negedge clk);
    chk(dreq == 0 && done_cnt == d0, "R4 zero length idle", {dreq, 8'(done_cnt - d0)}, 0);

    summary();
  end
endmodule